// File: doc/BRIEF.md
# Serial Channel Control Register Front End

This block is the control side of a single serial channel. A host writes a control port and a data port. Control writes go to one of eight write registers, picked by a pointer kept in the low bits of register 0. Once a non-zero register has been written, the pointer falls back to 0. The next control write therefore reaches register 0 again, and that register also carries a command field.

The commands reset the whole channel, clear individual interrupt-pending sources, or arm an interrupt on the next received character. Data-port writes load a transmit holding byte, but only while transmission is enabled in register 5. Register 5 also drives the DTR, RTS and break lines. Each line has a one-cycle change pulse that fires only when the written bit differs from the old value.

Four pending bits track the interrupt sources: transmit, status, receive and error. Each is gated by an enable bit in register 1 to form the interrupt request. Strobe inputs from the serializer and the line logic feed the sources and the read-status registers. These strobes are: byte taken from the holding buffer, character received, status event and error event.

Top module: `ser_chan_ctrl`

## Requirements
- R1: A control write lands in the write register whose index is held in bits 2:0 of register 0. Read select 3 returns that pointer in bits 2:0, with zeros above.
- R2: After a control write to any register other than 0, the pointer bits read back as 0. A write to register 0 loads them from the written byte.
- R3: While register 5 bit 3 (transmit enable) is 0, a data write leaves tx_buf_o, status 0 and pend_o unchanged.
- R4: An accepted data write loads tx_buf_o, clears status 0 bit 2 (transmit buffer empty) and clears pend_o bit 0 (transmit pending), all visible after the next clock edge.
- R5: tx_taken_i while the buffer holds a byte sets status 0 bit 2 and pend_o bit 0.
- R6: evt_stat_i sets pend_o bit 1 and status 2 bit 0. evt_err_i sets pend_o bit 3 and status 1 bit 5. Register 0 bits 5:3 carry the command. Code 010 clears only pend_o bit 1. Code 101 clears only pend_o bit 0. Code 110 clears only pend_o bit 3 and status 1 bit 5.
- R7: rx_char_i always sets status 0 bit 0. It sets pend_o bit 2 only when armed by command code 100, and the arming is used up by that character.
- R8: Command code 011 (channel reset) gives status 0 = 0x04, status 1 = 0 and status 2 = 0. It also clears all of pend_o and clears the receive arming.
- R9: dtr_o, rts_o and brk_o follow register 5 bits 7, 1 and 4, starting in the cycle after the write.
- R10: dtr_chg_o, rts_chg_o and brk_chg_o pulse for one cycle, aligned with the new level, only for bits that a register 5 write actually changed.
- R11: irq_o is high exactly when some pend_o bit i is set together with register 1 bit i.
- R12: After reset, the pointer is 0, status 0 reads 0x04, status 1 and status 2 read 0, and pend_o, irq_o, tx_buf_o and all line outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control-port write strobe |
| data_wr_i | input | 1 | Data-port write strobe |
| wdata_i | input | 8 | Write data for either port |
| tx_taken_i | input | 1 | Serializer took the holding byte |
| rx_char_i | input | 1 | Character received strobe |
| evt_stat_i | input | 1 | External status change event |
| evt_err_i | input | 1 | Receive error event |
| rd_sel_i | input | 2 | Read select: 0..2 status registers, 3 pointer |
| rd_data_o | output | 8 | Selected read value |
| pend_o | output | 4 | Pending bits {error, receive, status, transmit} |
| irq_o | output | 1 | Interrupt request |
| tx_buf_o | output | 8 | Transmit holding byte |
| dtr_o | output | 1 | DTR line level |
| rts_o | output | 1 | RTS line level |
| brk_o | output | 1 | Send-break level |
| dtr_chg_o | output | 1 | DTR change pulse |
| rts_chg_o | output | 1 | RTS change pulse |
| brk_chg_o | output | 1 | Break change pulse |

## Verification
The hardest case to reach is a data write that must be ignored while a transmit interrupt is already pending and a byte is already held. Without those conditions, an ignore that wrongly clears or reloads state looks the same as a correct one. The stimulus first enables transmission, loads a byte and returns it through tx_taken_i so that pending bit 0 and the empty flag are both set. It then clears only the enable bit and writes a different byte. Each clear-command is likewise issued with several sources pending at once, so that a command clearing the wrong bit shows up at pend_o.

// File: rtl/ser_chan_pkg.sv
package ser_chan_pkg;
  localparam int DW       = 8;
  localparam int NUM_WREG = 8;
  localparam int PW       = $clog2(NUM_WREG);
  localparam int NUM_SRC  = 4;

  // pending source indices
  localparam int SRC_TX   = 0;
  localparam int SRC_STAT = 1;
  localparam int SRC_RX   = 2;
  localparam int SRC_ERR  = 3;

  // register 5 bit positions
  localparam int R5_TXEN = 3;
  localparam int R5_DTR  = 7;
  localparam int R5_RTS  = 1;
  localparam int R5_BRK  = 4;
  localparam int LINE_REG = 5;

  // command field of register 0
  localparam int CMD_LSB = 3;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'b000,
    CMD_CLR_STAT = 3'b010,
    CMD_RST_CHAN = 3'b011,
    CMD_ARM_RX   = 3'b100,
    CMD_CLR_TX   = 3'b101,
    CMD_CLR_ERR  = 3'b110
  } cmd_e;

  typedef struct packed {
    logic rst_chan;
    logic clr_stat;
    logic arm_rx;
    logic clr_tx;
    logic clr_err;
  } cmd_t;
endpackage

// File: rtl/ser_wreg_file.sv
module ser_wreg_file
  import ser_chan_pkg::*;
#(
  parameter int N  = NUM_WREG,
  parameter int W  = DW,
  localparam int P = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic [W-1:0]       wdata_i,
  output logic [P-1:0]       ptr_o,
  output logic               reg0_wr_o,
  output logic [N-1:0][W-1:0] wreg_o,
  output logic [2:0]         line_o,
  output logic [2:0]         line_chg_o
);
  logic [N-1:0][W-1:0] regs_q;
  logic [P-1:0]        ptr;

  assign ptr       = regs_q[0][P-1:0];
  assign ptr_o     = ptr;
  assign reg0_wr_o = ctrl_wr_i && (ptr == '0);
  assign wreg_o    = regs_q;

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_r0
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[0] <= '0;
        else if (reg0_wr_o) regs_q[0] <= wdata_i;
        else if (ctrl_wr_i) regs_q[0][P-1:0] <= '0;  // pointer returns home
      end
    end else begin : g_rn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[i] <= '0;
        else if (ctrl_wr_i && ptr == P'(i)) regs_q[i] <= wdata_i;
      end
    end
  end

  // line order: 2 dtr, 1 rts, 0 brk
  localparam int LBIT [3] = '{R5_BRK, R5_RTS, R5_DTR};
  logic line_wr;
  assign line_wr = ctrl_wr_i && (ptr == P'(LINE_REG));

  for (genvar l = 0; l < 3; l++) begin : g_line
    logic chg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chg_q <= 1'b0;
      else         chg_q <= line_wr && (wdata_i[LBIT[l]] != regs_q[LINE_REG][LBIT[l]]);
    end
    assign line_o[l]     = regs_q[LINE_REG][LBIT[l]];
    assign line_chg_o[l] = chg_q;

    AST_CHG_IMPLIES_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_chg_o[l] |-> line_o[l] != $past(line_o[l]));  // R10
    AST_TOGGLE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_o[l] != $past(line_o[l]) |-> line_chg_o[l]);  // R10
  end

  AST_PTR_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ptr != '0 |=> ptr_o == '0);  // R2
endmodule

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
  import ser_chan_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         reg0_wr_i,
  input  logic [W-1:0] wdata_i,
  output cmd_t         cmd_o
);
  cmd_e code;
  assign code = cmd_e'(wdata_i[CMD_LSB +: 3]);

  always_comb begin
    cmd_o = '0;
    if (reg0_wr_i) begin
      unique case (code)
        CMD_CLR_STAT: cmd_o.clr_stat = 1'b1;
        CMD_RST_CHAN: cmd_o.rst_chan = 1'b1;
        CMD_ARM_RX:   cmd_o.arm_rx   = 1'b1;
        CMD_CLR_TX:   cmd_o.clr_tx   = 1'b1;
        CMD_CLR_ERR:  cmd_o.clr_err  = 1'b1;
        default:      cmd_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ser_int_ctrl.sv
module ser_int_ctrl
  import ser_chan_pkg::*;
#(
  parameter int S = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rst_chan_i,
  input  logic [S-1:0] set_i,
  input  logic [S-1:0] clr_i,
  input  logic         arm_i,
  input  logic         rx_char_i,
  input  logic [S-1:0] en_i,
  output logic         rx_hit_o,
  output logic [S-1:0] pend_o,
  output logic         irq_o
);
  logic         armed_q;
  logic [S-1:0] pend_q;

  assign rx_hit_o = rx_char_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (rst_chan_i) armed_q <= 1'b0;
    else if (arm_i)      armed_q <= 1'b1;
    else if (rx_char_i)  armed_q <= 1'b0;
  end

  for (genvar i = 0; i < S; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[i] <= 1'b0;
      else if (rst_chan_i) pend_q[i] <= 1'b0;
      else if (set_i[i])   pend_q[i] <= 1'b1;
      else if (clr_i[i])   pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

  AST_ARM_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_char_i && armed_q && !arm_i |=> !armed_q);  // R7
  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_chan_i |=> pend_o == '0 && !armed_q);  // R8
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o != '0);  // R11
endmodule

// File: rtl/ser_status_tx.sv
module ser_status_tx
  import ser_chan_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rst_chan_i,
  input  logic         data_wr_i,
  input  logic         tx_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tx_taken_i,
  input  logic         rx_char_i,
  input  logic         evt_stat_i,
  input  logic         evt_err_i,
  input  logic         clr_err_i,
  output logic         tx_set_o,
  output logic         tx_clr_o,
  output logic [W-1:0] tx_buf_o,
  output logic [W-1:0] stat0_o,
  output logic [W-1:0] stat1_o,
  output logic [W-1:0] stat2_o
);
  logic         empty_q, rx_av_q, err_q, stev_q;
  logic [W-1:0] buf_q;
  logic         accept;

  assign accept   = data_wr_i && tx_en_i;
  assign tx_clr_o = accept;
  assign tx_set_o = tx_taken_i && !empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= '0;
    else if (accept) buf_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      rx_av_q <= 1'b0;
      err_q   <= 1'b0;
      stev_q  <= 1'b0;
    end else if (rst_chan_i) begin
      empty_q <= 1'b1;
      rx_av_q <= 1'b0;
      err_q   <= 1'b0;
      stev_q  <= 1'b0;
    end else begin
      if (accept)        empty_q <= 1'b0;
      else if (tx_set_o) empty_q <= 1'b1;
      if (rx_char_i)     rx_av_q <= 1'b1;
      if (evt_err_i)     err_q   <= 1'b1;
      else if (clr_err_i) err_q  <= 1'b0;
      if (evt_stat_i)    stev_q  <= 1'b1;
    end
  end

  assign tx_buf_o = buf_q;
  assign stat0_o  = {{(W-3){1'b0}}, empty_q, 1'b0, rx_av_q};
  assign stat1_o  = {{(W-6){1'b0}}, err_q, 5'b0};
  assign stat2_o  = {{(W-1){1'b0}}, stev_q};

  AST_TX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && !tx_en_i && !rst_chan_i && !tx_taken_i
      |=> $stable(tx_buf_o) && $stable(empty_q));  // R3
  AST_TX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !rst_chan_i |=> tx_buf_o == $past(wdata_i) && !stat0_o[2]);  // R4
endmodule

// File: rtl/ser_chan_ctrl.sv
module ser_chan_ctrl
  import ser_chan_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_wr_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_taken_i,
  input  logic          rx_char_i,
  input  logic          evt_stat_i,
  input  logic          evt_err_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic          irq_o,
  output logic [DW-1:0] tx_buf_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          brk_o,
  output logic          dtr_chg_o,
  output logic          rts_chg_o,
  output logic          brk_chg_o
);
  logic [PW-1:0]                ptr;
  logic                         reg0_wr;
  logic [NUM_WREG-1:0][DW-1:0]  wreg;
  logic [2:0]                   line, line_chg;
  cmd_t                         cmd;
  logic                         tx_set, tx_clr, rx_hit;
  logic [DW-1:0]                stat0, stat1, stat2;
  logic [NUM_SRC-1:0]           set_v, clr_v;

  ser_wreg_file #(.N(NUM_WREG), .W(DW)) i_wreg (
    .clk_i, .rst_ni, .ctrl_wr_i, .wdata_i,
    .ptr_o(ptr), .reg0_wr_o(reg0_wr), .wreg_o(wreg),
    .line_o(line), .line_chg_o(line_chg)
  );

  ser_cmd_decode #(.W(DW)) i_dec (
    .reg0_wr_i(reg0_wr), .wdata_i, .cmd_o(cmd)
  );

  ser_status_tx #(.W(DW)) i_stat (
    .clk_i, .rst_ni, .rst_chan_i(cmd.rst_chan), .data_wr_i,
    .tx_en_i(wreg[LINE_REG][R5_TXEN]), .wdata_i, .tx_taken_i, .rx_char_i,
    .evt_stat_i, .evt_err_i, .clr_err_i(cmd.clr_err),
    .tx_set_o(tx_set), .tx_clr_o(tx_clr), .tx_buf_o,
    .stat0_o(stat0), .stat1_o(stat1), .stat2_o(stat2)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_TX]   = tx_set;
    set_v[SRC_STAT] = evt_stat_i;
    set_v[SRC_RX]   = rx_hit;
    set_v[SRC_ERR]  = evt_err_i;
    clr_v[SRC_TX]   = tx_clr | cmd.clr_tx;
    clr_v[SRC_STAT] = cmd.clr_stat;
    clr_v[SRC_ERR]  = cmd.clr_err;
  end

  ser_int_ctrl #(.S(NUM_SRC)) i_int (
    .clk_i, .rst_ni, .rst_chan_i(cmd.rst_chan), .set_i(set_v), .clr_i(clr_v),
    .arm_i(cmd.arm_rx), .rx_char_i, .en_i(wreg[1][NUM_SRC-1:0]),
    .rx_hit_o(rx_hit), .pend_o, .irq_o
  );

  always_comb begin
    unique case (rd_sel_i)
      2'd0: rd_data_o = stat0;
      2'd1: rd_data_o = stat1;
      2'd2: rd_data_o = stat2;
      default: rd_data_o = {{(DW-PW){1'b0}}, ptr};
    endcase
  end

  assign dtr_o     = line[2];
  assign rts_o     = line[1];
  assign brk_o     = line[0];
  assign dtr_chg_o = line_chg[2];
  assign rts_chg_o = line_chg[1];
  assign brk_chg_o = line_chg[0];

  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd));  // R6
  AST_CMD_ONLY_ON_REG0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd != '0 |-> ctrl_wr_i);  // R6
endmodule

// File: tb/test_ser_chan_ctrl.sv
`timescale 1ns/1ps
module test_ser_chan_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 0, data_wr = 0, tx_taken = 0, rx_char = 0, evt_stat = 0, evt_err = 0;
  logic [7:0] wdata = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data, tx_buf;
  logic [3:0] pend;
  logic       irq, dtr, rts, brk, dtr_chg, rts_chg, brk_chg;

  always #2 clk = ~clk;

  ser_chan_ctrl i_ser_chan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .data_wr_i(data_wr),
    .wdata_i(wdata), .tx_taken_i(tx_taken), .rx_char_i(rx_char),
    .evt_stat_i(evt_stat), .evt_err_i(evt_err), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .pend_o(pend), .irq_o(irq), .tx_buf_o(tx_buf),
    .dtr_o(dtr), .rts_o(rts), .brk_o(brk),
    .dtr_chg_o(dtr_chg), .rts_chg_o(rts_chg), .brk_chg_o(brk_chg)
  );

  typedef struct {
    string tag;
    int    src;
    int    exp;
  } item_t;

  item_t q[$];
  int    errors = 0, checks = 0;
  bit    mon_busy = 0, done = 0;

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      item_t it;
      int    act;
      wait (q.size() > 0);
      mon_busy = 1;
      it = q.pop_front();
      if (it.src < 4) begin
        rd_sel = it.src[1:0];
        #0.1;
      end
      case (it.src)
        0, 1, 2, 3: act = int'(rd_data);
        4: act = int'(pend);
        5: act = int'(irq);
        6: act = int'(tx_buf);
        7: act = int'({dtr, rts, brk});
        default: act = int'({dtr_chg, rts_chg, brk_chg});
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s src%0d: actual=%0h expected=%0h", it.tag, it.src, act, it.exp);
      end
      mon_busy = 0;
    end
  end

  task automatic expect_v(string tag, int src, int exp);
    item_t it;
    it.tag = tag; it.src = src; it.exp = exp;
    q.push_back(it);
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic cwr(logic [7:0] d);
    wdata = d; ctrl_wr = 1;
    @(posedge clk); @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic dwr(logic [7:0] d);
    wdata = d; data_wr = 1;
    @(posedge clk); @(negedge clk);
    data_wr = 0;
  endtask

  task automatic strobe(int which);
    case (which)
      0: tx_taken = 1;
      1: rx_char  = 1;
      2: evt_stat = 1;
      default: evt_err = 1;
    endcase
    @(posedge clk); @(negedge clk);
    tx_taken = 0; rx_char = 0; evt_stat = 0; evt_err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    expect_v("R12 stat0", 0, 8'h04);
    expect_v("R12 stat1", 1, 0);
    expect_v("R12 stat2", 2, 0);
    expect_v("R12 ptr", 3, 0);
    expect_v("R12 pend", 4, 0);
    expect_v("R12 irq", 5, 0);
    expect_v("R12 txbuf", 6, 0);
    expect_v("R12 lines", 7, 0);

    // R1 / R2 pointer, R9 / R10 lines
    cwr(8'h05);
    expect_v("R1 ptr", 3, 5);
    cwr(8'h92);
    expect_v("R2 ptr home", 3, 0);
    expect_v("R9 lines", 7, 3'b111);
    expect_v("R10 chg all", 8, 3'b111);
    @(negedge clk);
    expect_v("R10 pulse one cycle", 8, 0);
    cwr(8'h05); cwr(8'h92);
    expect_v("R10 same value no chg", 8, 0);
    cwr(8'h05); cwr(8'h82);
    expect_v("R10 brk only chg", 8, 3'b001);
    expect_v("R9 brk low", 7, 3'b110);

    // R5 / R3 / R4 transmit path
    cwr(8'h05); cwr(8'h8A);
    dwr(8'h11);
    expect_v("R4 load", 6, 8'h11);
    expect_v("R4 not empty", 0, 8'h00);
    strobe(0);
    expect_v("R5 empty", 0, 8'h04);
    expect_v("R5 tx pend", 4, 4'b0001);
    cwr(8'h05); cwr(8'h82);
    dwr(8'h33);
    expect_v("R3 buf kept", 6, 8'h11);
    expect_v("R3 stat0 kept", 0, 8'h04);
    expect_v("R3 pend kept", 4, 4'b0001);
    cwr(8'h05); cwr(8'h8A);
    dwr(8'h5A);
    expect_v("R4 buf", 6, 8'h5A);
    expect_v("R4 stat0", 0, 8'h00);
    expect_v("R4 pend cleared", 4, 0);

    // R11 irq gating
    cwr(8'h01); cwr(8'h0F);
    strobe(0);
    expect_v("R11 irq on", 5, 1);
    cwr(8'h01); cwr(8'h0E);
    expect_v("R11 irq masked", 5, 0);
    expect_v("R11 pend stays", 4, 4'b0001);

    // R6 source-specific clears
    strobe(2); strobe(3);
    expect_v("R6 pend set", 4, 4'b1011);
    expect_v("R6 stat1", 1, 8'h20);
    expect_v("R6 stat2", 2, 8'h01);
    expect_v("R11 irq stat", 5, 1);
    cwr(8'h10);
    expect_v("R6 clr stat", 4, 4'b1001);
    cwr(8'h28);
    expect_v("R6 clr tx", 4, 4'b1000);
    cwr(8'h30);
    expect_v("R6 clr err", 4, 4'b0000);
    expect_v("R6 stat1 clr", 1, 8'h00);

    // R7 receive arming
    strobe(1);
    expect_v("R7 unarmed", 4, 0);
    expect_v("R7 rx avail", 0, 8'h05);
    cwr(8'h20);
    strobe(1);
    expect_v("R7 armed hit", 4, 4'b0100);

    // R8 channel reset
    strobe(3); strobe(2);
    cwr(8'h20);
    cwr(8'h18);
    expect_v("R8 stat0", 0, 8'h04);
    expect_v("R8 stat1", 1, 0);
    expect_v("R8 stat2", 2, 0);
    expect_v("R8 pend", 4, 0);
    strobe(1);
    expect_v("R8 arm cleared", 4, 0);
    expect_v("R8 lines kept", 7, 3'b110);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule